// File: doc/BRIEF.md
# Cascadable Reloading Timer Bank

The block holds four 16-bit up-counters that share one system clock. Each counter has a programmable start value and a small control register. A counter advances either on a divided version of the system clock or, when chained, once for each wrap of the counter one index below it. When a counter steps past its top value, it reloads from its start value instead of returning to zero. If that timer's interrupt is armed, a one-cycle request pulse follows on the timer's own output line.

Software uses one write port and one read port. Each port picks a timer by index and picks a register with a select bit. A write with the select bit low sets the start value, and a read with it low returns the live count. With the select bit high, both ports reach the control register. Chaining timers gives intervals longer than 16 bits. Timer 0 has nothing below it, so a chained timer 0 stays frozen.

Top module: `tmr_bank`

## Requirements
- R1: The divider code in control bits 1:0 sets the tick period of an enabled, unchained timer. Code 0 gives 1 clock, 1 gives 64, 2 gives 256 and 3 gives 1024. The first increment comes exactly one period after the clock edge that performs the control write.
- R2: Each tick adds one to the count. A tick taken at 0xFFFF is an overflow, and it loads the start value into the count.
- R3: Control bit 6 arms the interrupt. An overflow with that bit set drives the timer's `irq` bit high for exactly the next cycle. With the bit clear, the line stays low.
- R4: Control bit 2 chains the timer. An enabled chained timer ignores the divider and advances once for each overflow of the timer at index minus one, on the same clock edge as that overflow.
- R5: Timer 0 has no predecessor. While it is chained, its count never changes.
- R6: While enable (control bit 7) is clear, the timer's count holds its value.
- R7: Every control write clears that timer's divider phase. No divider tick is taken on the write edge itself.
- R8: A control write that sets enable while it was clear loads the start value into the count on the write edge.
- R9: Register select 0 writes the start value and reads the count. Select 1 writes and reads the control register. Control readback returns bits 7, 6, 2, 1 and 0 as written, and all other bits read as zero. Writing a start value does not change the running count.
- R10: After reset, every count, start value and control register is zero, and all `irq` lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_idx | input | 2 | Timer addressed by the write |
| wr_ctl | input | 1 | Write select: 0 start value, 1 control |
| wr_data | input | 16 | Write data |
| rd_idx | input | 2 | Timer addressed by the read |
| rd_ctl | input | 1 | Read select: 0 live count, 1 control |
| rd_data | output | 16 | Read data, combinational |
| irq | output | 4 | Per-timer interrupt pulse |

## Verification
The hardest behaviour to reach from the ports is a chain of timers where a wrap ripples up through several counters on one edge. This needs lower timers running at divider code 0 with start values just under 0xFFFF. The directed part of the bench sets up such a chain, with a period of four clocks, and counts the cascaded increments over a known window. The random part biases start values toward 0xFFC0 and above, and divider codes toward 0, so that multi-level ripples and simultaneous interrupts happen often. A cycle model checks the result throughout.

// File: rtl/tmr_pkg.sv
// Package: shared types and helpers for the timer bank.
// Assumes the control register occupies the low 8 bits of the data word.
package tmr_pkg;

    localparam int ACC_W = 10;   // divider phase width, enough for the 1024 period

    typedef struct packed {
        logic       en;
        logic       ie;
        logic       cas;
        logic [1:0] pre;
    } tmr_ctl_t;

    // Shift amount for a divider code (period = 1 << shift)
    function automatic int unsigned pre_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 10;
        endcase
    endfunction

    // Unpack the low control byte into fields
    function automatic tmr_ctl_t decode_ctl(input logic [7:0] d);
        tmr_ctl_t c;
        c.en  = d[7];
        c.ie  = d[6];
        c.cas = d[2];
        c.pre = d[1:0];
        return c;
    endfunction

    // Pack the fields back into the control byte, unused bits zero
    function automatic logic [7:0] encode_ctl(input tmr_ctl_t c);
        return {c.en, c.ie, 3'b000, c.cas, c.pre};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Module: divider phase for one timer.
// Emits a one-cycle tick every 2^shift clocks while run is high.
// A clear restarts the phase and suppresses the tick in that cycle.
// Assumes sel only changes together with clr.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int ACC_BITS = ACC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [ACC_BITS-1:0] acc_q;
    logic [ACC_BITS-1:0] lim;
    logic [ACC_BITS:0]   period;

    // Terminal phase value for the selected divider
    always_comb begin
        period = (ACC_BITS+1)'(1) << pre_shift(sel);
        lim    = ACC_BITS'(period - 1'b1);
    end

    // Tick when the phase reaches its terminal value
    assign tick = run && !clr && (acc_q == lim);

    // Advance the phase, restart it on clear, idle or terminal value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr || !run || (acc_q == lim)) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + 1'b1;
        end
    end

    // The phase never passes the terminal value of the current divider
    p_phase_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= lim);

endmodule

// File: rtl/tmr_channel.sv
// Module: one timer, holding the start value, control and count registers.
// Counts divider ticks, or overflows from its predecessor when chained.
// Reloads from the start value on overflow and pulses irq when armed.
// Assumes ctl_we and rld_we are never high together.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pred_ovf,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt,
    output tmr_ctl_t         ctl,
    output logic             irq
);

    tmr_ctl_t         ctl_q;
    tmr_ctl_t         new_ctl;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             ptick;
    logic             ctick;
    logic             tick;
    logic             start;

    tmr_prescaler #(.ACC_BITS(ACC_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.en && !ctl_q.cas),
        .clr   (ctl_we),
        .sel   (ctl_q.pre),
        .tick  (ptick)
    );

    // Tick sources, overflow detection and enable rising edge
    always_comb begin
        new_ctl = decode_ctl(wdata[7:0]);
        ctick   = ctl_q.en && ctl_q.cas && pred_ovf;
        tick    = ptick || ctick;
        ovf     = tick && (cnt_q == {CNT_W{1'b1}});
        start   = ctl_we && new_ctl.en && !ctl_q.en;
    end

    // Control and start value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            rld_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= new_ctl;
            if (rld_we) rld_q <= wdata;
        end
    end

    // Count register: load on start or overflow, else step on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || ovf) begin
            cnt_q <= rld_q;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Interrupt pulse one cycle after an armed overflow
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf && ctl_q.ie;
    end

    assign cnt = cnt_q;
    assign ctl = ctl_q;
    assign irq = irq_q;

    p_reload_on_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == $past(rld_q)));

    p_irq_needs_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(ctl_q.ie));

    p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.en && !ctl_we) |=> $stable(cnt_q));

    p_no_tick_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |-> !ptick);

    p_start_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(rld_q)));

endmodule

// File: rtl/tmr_bank.sv
// Module: top of the timer bank, with N_TMR chained channels.
// Decodes the single write port into per-timer strobes, builds the
// overflow chain and muxes the combinational read port.
// Assumes N_TMR is a power of two and CNT_W is at least 8.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4,
    parameter int CNT_W = 16,
    localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_ctl,
    output logic [CNT_W-1:0] rd_data,
    output logic [N_TMR-1:0] irq
);

    logic [N_TMR-1:0] ovf_v;
    logic [N_TMR-1:0] pred_v;
    logic [N_TMR-1:0] ctl_we_v;
    logic [N_TMR-1:0] rld_we_v;
    logic [CNT_W-1:0] cnt_a [N_TMR];
    tmr_ctl_t         ctl_a [N_TMR];

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        // Write strobes for this timer
        assign ctl_we_v[g] = wr_en && wr_ctl  && (wr_idx == IDX_W'(g));
        assign rld_we_v[g] = wr_en && !wr_ctl && (wr_idx == IDX_W'(g));

        // Chain input: the lowest timer has no predecessor
        if (g == 0) begin : g_head
            assign pred_v[g] = 1'b0;
        end else begin : g_link
            assign pred_v[g] = ovf_v[g-1];
        end

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (ctl_we_v[g]),
            .rld_we   (rld_we_v[g]),
            .wdata    (wr_data),
            .pred_ovf (pred_v[g]),
            .ovf      (ovf_v[g]),
            .cnt      (cnt_a[g]),
            .ctl      (ctl_a[g]),
            .irq      (irq[g])
        );
    end

    // Read port mux
    always_comb begin
        if (rd_ctl) rd_data = {{(CNT_W-8){1'b0}}, encode_ctl(ctl_a[rd_idx])};
        else        rd_data = cnt_a[rd_idx];
    end

    p_head_chained_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[0].cas && !ctl_we_v[0]) |=> $stable(cnt_a[0]));

    p_top_irq_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_v[N_TMR-1] && ctl_a[N_TMR-1].ie) |=> irq[N_TMR-1]);

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/100ps
module tmr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_ctl = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic        rd_ctl = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit irq_watch = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_ctl(rd_ctl), .rd_data(rd_data), .irq(irq)
    );

    // Reference model state, built from the requirements
    logic [15:0] m_cnt [4];
    logic [15:0] m_rld [4];
    int          m_acc [4];
    logic [7:0]  m_ctl [4];
    logic [3:0]  m_irq;

    function automatic int period_of(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 64;
            2'd2: return 256;
            default: return 1024;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [3:0] ov;
        logic [3:0] tk;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = '0; m_rld[i] = '0; m_acc[i] = 0; m_ctl[i] = '0;
            end
            m_irq = '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit cw;
                bit en;
                bit cas;
                cw  = wr_en && wr_ctl && (wr_idx == 2'(i));
                en  = m_ctl[i][7];
                cas = m_ctl[i][2];
                tk[i] = (en && !cas && !cw && (m_acc[i] == period_of(m_ctl[i][1:0]) - 1))
                      || (en && cas && (i > 0) && ov[(i > 0) ? i-1 : 0]);
                ov[i] = tk[i] && (m_cnt[i] == 16'hFFFF);
            end
            for (int i = 0; i < 4; i++) begin
                bit cw;
                bit run;
                cw  = wr_en && wr_ctl && (wr_idx == 2'(i));
                run = m_ctl[i][7] && !m_ctl[i][2];
                m_irq[i] = ov[i] && m_ctl[i][6];
                if (cw && wr_data[7] && !m_ctl[i][7]) m_cnt[i] = m_rld[i];
                else if (ov[i])                        m_cnt[i] = m_rld[i];
                else if (tk[i])                        m_cnt[i] = m_cnt[i] + 16'd1;
                if (cw || !run || m_acc[i] == period_of(m_ctl[i][1:0]) - 1) m_acc[i] = 0;
                else m_acc[i] = m_acc[i] + 1;
                if (cw) m_ctl[i] = wr_data[7:0] & 8'hC7;
                if (wr_en && !wr_ctl && wr_idx == 2'(i)) m_rld[i] = wr_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Interrupt lines against the model, every cycle
    always @(negedge clk) begin
        if (irq_watch) chk("R3 irq vs model", {12'd0, irq}, {12'd0, m_irq});
    end

    task automatic rd_cnt(input int idx, input string tag, input logic [15:0] exp);
        rd_idx = 2'(idx); rd_ctl = 1'b0; #0.2;
        chk(tag, rd_data, exp);
    endtask

    task automatic rd_reg(input int idx, input string tag, input logic [15:0] exp);
        rd_idx = 2'(idx); rd_ctl = 1'b1; #0.2;
        chk(tag, rd_data, exp);
        rd_ctl = 1'b0;
    endtask

    task automatic cmp_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_cnt(i, tag, m_cnt[i]);
            rd_reg(i, "R9 ctl vs model", {8'd0, m_ctl[i]});
        end
    endtask

    // One register write, entered and left at a falling edge
    task automatic wr(input int idx, input bit sel, input logic [15:0] d);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_ctl = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        irq_watch = 1'b1;

        // R10: reset state
        for (int i = 0; i < 4; i++) begin
            rd_cnt(i, "R10 count after reset", 16'h0000);
            rd_reg(i, "R10 ctl after reset", 16'h0000);
        end
        chk("R10 irq after reset", {12'd0, irq}, 16'h0000);

        // R8, R2, R3: divider code 0, wrap from 0xFFFF to the start value
        wr(0, 1'b0, 16'hFFFC);
        wr(0, 1'b1, 16'h00C0);
        rd_cnt(0, "R8 start value loaded", 16'hFFFC);
        wait_n(1); rd_cnt(0, "R1 code0 step", 16'hFFFD);
        wait_n(2); rd_cnt(0, "R2 at top", 16'hFFFF);
        chk("R3 no irq before wrap", {15'd0, irq[0]}, 16'd0);
        wait_n(1); rd_cnt(0, "R2 reload on wrap", 16'hFFFC);
        chk("R3 irq pulse", {15'd0, irq[0]}, 16'd1);
        wait_n(1); rd_cnt(0, "R2 after reload", 16'hFFFD);
        chk("R3 pulse one cycle", {15'd0, irq[0]}, 16'd0);

        // R4: timer 1 chained to timer 0 (wrap every 4 clocks), irq disarmed
        wr(1, 1'b0, 16'h0010);
        wr(1, 1'b1, 16'h0084);
        rd_cnt(1, "R4 chained start", 16'h0010);
        wait_n(36); rd_cnt(1, "R4 nine wraps", 16'h0019);
        wait_n(4);  rd_cnt(1, "R4 ten wraps", 16'h001A);
        chk("R3 disarmed stays low", {15'd0, irq[1]}, 16'd0);
        cmp_all("R4 chain vs model");

        // R5: timer 0 chained has no source
        wr(0, 1'b1, 16'h00C4);
        rd_cnt(0, "R5 read", m_cnt[0]);
        v = m_cnt[0];
        wait_n(50); rd_cnt(0, "R5 frozen", v);

        // R1: code 1 on timer 2, first step 64 clocks after the write
        wr(2, 1'b1, 16'h0081);
        rd_cnt(2, "R8 start from zero", 16'h0000);
        wait_n(63); rd_cnt(2, "R1 code1 before period", 16'h0000);
        wait_n(1);  rd_cnt(2, "R1 code1 at period", 16'h0001);

        // R7: rewrite mid-phase restarts the divider
        wait_n(40);
        wr(2, 1'b1, 16'h0081);
        wait_n(63); rd_cnt(2, "R7 phase restarted", 16'h0001);
        wait_n(1);  rd_cnt(2, "R7 full period after write", 16'h0002);

        // R6: disabled timer holds
        wr(2, 1'b1, 16'h0001);
        wait_n(100); rd_cnt(2, "R6 hold while off", 16'h0002);

        // R9: readback masking and start value write not touching the count
        wr(1, 1'b1, 16'hFF7D);
        rd_reg(1, "R9 ctl masked", 16'h0045);
        v = m_cnt[2];
        wr(2, 1'b0, 16'h1234);
        rd_cnt(2, "R9 start write leaves count", v);

        // R1: code 3 on timer 3
        wr(3, 1'b1, 16'h0083);
        wait_n(1023); rd_cnt(3, "R1 code3 before period", 16'h0000);
        wait_n(1);    rd_cnt(3, "R1 code3 at period", 16'h0001);
        wr(3, 1'b1, 16'h0000);

        // Random phase, biased toward short periods and near-top start values
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 6) begin
                logic [15:0] d;
                d = 16'($urandom);
                d[1:0] = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
                d[7] = ($urandom % 4 != 0);
                wr_en = 1'b1; wr_ctl = 1'b1; wr_idx = 2'($urandom); wr_data = d;
            end else if (r < 12) begin
                wr_en = 1'b1; wr_ctl = 1'b0; wr_idx = 2'($urandom);
                wr_data = ($urandom % 5 == 0) ? 16'($urandom) : (16'hFFC0 | 16'($urandom % 64));
            end
            @(negedge clk);
            wr_en = 1'b0;
            if (k % 4 == 0) cmp_all("R2 count vs model");
        end

        irq_watch = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule